// File: doc/BRIEF.md
# Flash Command Protection Controller

This block stands in front of a flash controller's command path and decides, for every command strobe, whether the command may go to the program/erase engine. The decision uses five inputs: a two-bit write-enable key, a two-bit mode-entry field, a per-block write-permission vector, a permission-override bit and the current engine activity. An accepted program, erase or suspend command is forwarded as a one-cycle start pulse that carries the command code and block index. A rejected command is dropped and classified into sticky error flags.

Any violation forces a sticky command-locked state. An engine fault or a prohibited-access event signalled by neighbouring logic also forces it. A program or erase that is already running keeps going through the lock, but it can no longer be suspended. The lock and every flag are released only by a status-clear command issued while the access-status input equals 10h. A level interrupt reports the lock and the access-violation flag, each behind its own enable.

Command codes: 1 = program, 2 = erase, 3 = suspend, 4 = status clear. Every other code is undefined. In `blk_wr_ok`, bit n = 1 means block n may be written.

Top module: `flash_cmd_guard`

## Requirements
- R1: After reset, the lock, all five error flags, `op_busy`, `eng_start` and `irq` are 0.
- R2: An accepted program or erase raises `eng_start` for exactly one cycle, on the clock after the command, with `eng_code`/`eng_blk` equal to the command's code and block, and sets `op_busy` until `eng_done`. A rejected command never raises `eng_start`, and `eng_start` is never high while locked.
- R3: A program (erase) issued while `wen_key` is not 01b sets the program (erase) error flag and the lock.
- R4: Any command issued while `mode_ent` is 00b sets the illegal-command flag and the lock.
- R5: While `lock_ovr` is 0, a program or erase to a block whose `blk_wr_ok` bit is 0 sets the program or erase error flag and the lock. With `lock_ovr` = 1 the same command is accepted.
- R6: An undefined command code sets the illegal-command flag and the lock.
- R7: While `op_busy` is 1 and the block is unlocked, a suspend is accepted (start pulse with code 3). Any other command sets illegal-command and the lock, while `op_busy` stays 1 until `eng_done`.
- R8: While locked, any command other than a valid clear sets the illegal-command flag. A suspend is refused and produces no start.
- R9: A status-clear (code 4) while locked and `acc_stat` = 10h clears the lock and all flags. With any other `acc_stat` the lock stays and illegal-command is set.
- R10: `eng_fault` sets the controller-error flag and the lock. `acc_viol` sets the access-violation flag and the lock.
- R11: `irq` = (`irq_en_lock` AND lock) OR (`irq_en_acc` AND access-violation flag). It is a level that falls once the flags are cleared.
- R12: Violations detected in the same cycle set all their flags together. Flags are sticky until a valid clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code |
| cmd_blk | input | BLK_W | Target block index |
| wen_key | input | 2 | Write-enable key, 01b allows program/erase |
| mode_ent | input | 2 | Mode-entry field, 00b is read mode |
| blk_wr_ok | input | NBLK | Per-block write permission |
| lock_ovr | input | 1 | Overrides block write permission |
| acc_stat | input | ACC_W | Access-status value tested by the clear command |
| irq_en_lock | input | 1 | Interrupt enable for the lock |
| irq_en_acc | input | 1 | Interrupt enable for the access-violation flag |
| eng_fault | input | 1 | Engine internal fault event |
| acc_viol | input | 1 | Prohibited-access event |
| eng_done | input | 1 | Engine finished the running operation |
| eng_start | output | 1 | One-cycle start to engine |
| eng_code | output | 3 | Forwarded command code |
| eng_blk | output | BLK_W | Forwarded block index |
| op_busy | output | 1 | Program/erase in progress |
| cmd_locked | output | 1 | Command-locked state |
| flg_illegal | output | 1 | Illegal-command flag |
| flg_erase | output | 1 | Erase error flag |
| flg_prog | output | 1 | Program error flag |
| flg_ctrl | output | 1 | Controller error flag |
| flg_acc | output | 1 | Access-violation flag |
| irq | output | 1 | Level error interrupt |

## Verification
Legal program and erase commands to several blocks show that forwarding keeps code and index. The key, read-mode, block-permission and undefined-code patterns are each applied alone, which shows that each one raises its own flag and no other. A busy window tried with a suspend, then a second command, then a suspend again separates acceptance during activity from refusal under lock. A combined read-mode plus bad-key command shows that flags from the same cycle merge. Clears issued with the right and the wrong access-status value tell a true release from the illegal path.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int CODE_W = 3;
  typedef enum logic [CODE_W-1:0] {
    C_PROG  = 3'd1,
    C_ERASE = 3'd2,
    C_SUSP  = 3'd3,
    C_CLEAR = 3'd4
  } cmd_e;
  localparam logic [1:0] KEY_OPEN = 2'b01;
  localparam logic [1:0] MODE_READ = 2'b00;
  localparam logic [7:0] CLR_STAT = 8'h10;
endpackage

// File: rtl/fcg_decide.sv
module fcg_decide
  import fcg_pkg::*;
#(
  parameter int NBLK  = 16,
  parameter int ACC_W = 8,
  localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [BLK_W-1:0]  cmd_blk,
  input  logic [1:0]        wen_key,
  input  logic [1:0]        mode_ent,
  input  logic [NBLK-1:0]   blk_wr_ok,
  input  logic              lock_ovr,
  input  logic [ACC_W-1:0]  acc_stat,
  input  logic              locked,
  input  logic              busy,
  input  logic              evt_any,
  output logic              viol_ill,
  output logic              viol_prg,
  output logic              viol_ers,
  output logic              accept,
  output logic              clr_go
);
  logic is_prog, is_ers, is_susp, is_clr, known, key_ok, blk_ok, rd_mode;

  always_comb begin
    is_prog = (cmd_code == C_PROG);
    is_ers  = (cmd_code == C_ERASE);
    is_susp = (cmd_code == C_SUSP);
    is_clr  = (cmd_code == C_CLEAR);
    known   = is_prog | is_ers | is_susp | is_clr;
    key_ok  = (wen_key == KEY_OPEN);
    rd_mode = (mode_ent == MODE_READ);
    blk_ok  = lock_ovr;
    if (int'(cmd_blk) < NBLK) blk_ok = lock_ovr | blk_wr_ok[cmd_blk];
  end

  always_comb begin
    viol_ill = 1'b0;
    viol_prg = 1'b0;
    viol_ers = 1'b0;
    accept   = 1'b0;
    clr_go   = 1'b0;
    if (cmd_valid) begin
      if (locked) begin
        clr_go   = is_clr && (acc_stat == ACC_W'(CLR_STAT));
        viol_ill = !clr_go;
      end else begin
        viol_ill = rd_mode | !known | (busy & !is_susp) | (is_susp & !busy);
        viol_prg = is_prog & (!key_ok | !blk_ok);
        viol_ers = is_ers & (!key_ok | !blk_ok);
        clr_go   = is_clr & !viol_ill;
        accept   = (is_prog | is_ers | is_susp) & !viol_ill & !viol_prg
                   & !viol_ers & !evt_any;
      end
    end
  end
endmodule

// File: rtl/fcg_status.sv
module fcg_status (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_go,
  input  logic set_ill,
  input  logic set_ers,
  input  logic set_prg,
  input  logic set_ctl,
  input  logic set_acc,
  output logic locked,
  output logic [4:0] flags
);
  logic       locked_n;
  logic [4:0] flags_n;
  logic [4:0] set_v;

  always_comb begin
    set_v    = {set_acc, set_ctl, set_prg, set_ers, set_ill};
    flags_n  = clr_go ? 5'b0 : flags;
    flags_n  = flags_n | set_v;
    locked_n = ((clr_go ? 1'b0 : locked)) | (|set_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      flags  <= 5'b0;
    end else begin
      locked <= locked_n;
      flags  <= flags_n;
    end
  end

  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !clr_go) |=> flags[0]);
  // R10
  flag_implies_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags) |-> locked);
  // R9
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(clr_go));
endmodule

// File: rtl/fcg_engine_if.sv
module fcg_engine_if
  import fcg_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [BLK_W-1:0]  cmd_blk,
  input  logic              eng_done,
  output logic              start,
  output logic [CODE_W-1:0] code_q,
  output logic [BLK_W-1:0]  blk_q,
  output logic              busy
);
  logic busy_n, pe_go;

  always_comb begin
    pe_go  = accept && (cmd_code == C_PROG || cmd_code == C_ERASE);
    busy_n = busy;
    if (pe_go) busy_n = 1'b1;
    else if (eng_done) busy_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start  <= 1'b0;
      code_q <= '0;
      blk_q  <= '0;
      busy   <= 1'b0;
    end else begin
      start <= accept;
      busy  <= busy_n;
      if (accept) begin
        code_q <= cmd_code;
        blk_q  <= cmd_blk;
      end
    end
  end

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_done) |=> busy);
  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(accept));
endmodule

// File: rtl/flash_cmd_guard.sv
module flash_cmd_guard
  import fcg_pkg::*;
#(
  parameter int NBLK  = 16,
  parameter int ACC_W = 8,
  localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  input  logic [BLK_W-1:0]  cmd_blk,
  input  logic [1:0]        wen_key,
  input  logic [1:0]        mode_ent,
  input  logic [NBLK-1:0]   blk_wr_ok,
  input  logic              lock_ovr,
  input  logic [ACC_W-1:0]  acc_stat,
  input  logic              irq_en_lock,
  input  logic              irq_en_acc,
  input  logic              eng_fault,
  input  logic              acc_viol,
  input  logic              eng_done,
  output logic              eng_start,
  output logic [2:0]        eng_code,
  output logic [BLK_W-1:0]  eng_blk,
  output logic              op_busy,
  output logic              cmd_locked,
  output logic              flg_illegal,
  output logic              flg_erase,
  output logic              flg_prog,
  output logic              flg_ctrl,
  output logic              flg_acc,
  output logic              irq
);
  logic       viol_ill, viol_prg, viol_ers, accept, clr_go;
  logic [4:0] flags;

  fcg_decide #(.NBLK(NBLK), .ACC_W(ACC_W)) u_decide (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_blk   (cmd_blk),
    .wen_key   (wen_key),
    .mode_ent  (mode_ent),
    .blk_wr_ok (blk_wr_ok),
    .lock_ovr  (lock_ovr),
    .acc_stat  (acc_stat),
    .locked    (cmd_locked),
    .busy      (op_busy),
    .evt_any   (eng_fault | acc_viol),
    .viol_ill  (viol_ill),
    .viol_prg  (viol_prg),
    .viol_ers  (viol_ers),
    .accept    (accept),
    .clr_go    (clr_go)
  );

  fcg_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_go  (clr_go),
    .set_ill (viol_ill),
    .set_ers (viol_ers),
    .set_prg (viol_prg),
    .set_ctl (eng_fault),
    .set_acc (acc_viol),
    .locked  (cmd_locked),
    .flags   (flags)
  );

  fcg_engine_if #(.BLK_W(BLK_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .cmd_code (cmd_code),
    .cmd_blk  (cmd_blk),
    .eng_done (eng_done),
    .start    (eng_start),
    .code_q   (eng_code),
    .blk_q    (eng_blk),
    .busy     (op_busy)
  );

  always_comb begin
    flg_illegal = flags[0];
    flg_erase   = flags[1];
    flg_prog    = flags[2];
    flg_ctrl    = flags[3];
    flg_acc     = flags[4];
    irq         = (irq_en_lock & cmd_locked) | (irq_en_acc & flg_acc);
  end

  // R8
  no_start_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !cmd_locked);
  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cmd_locked || flg_acc));
endmodule

// File: tb/test_flash_cmd_guard.sv
module test_flash_cmd_guard;
  localparam int CLK_PER = 10;
  localparam int NBLK = 16;
  localparam int BLK_W = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_code = 0;
  logic [BLK_W-1:0] cmd_blk = 0;
  logic [1:0] wen_key = 2'b01, mode_ent = 2'b01;
  logic [NBLK-1:0] blk_wr_ok = '1;
  logic lock_ovr = 0;
  logic [7:0] acc_stat = 0;
  logic irq_en_lock = 0, irq_en_acc = 0, eng_fault = 0, acc_viol = 0, eng_done = 0;
  logic eng_start, op_busy, cmd_locked, flg_illegal, flg_erase, flg_prog, flg_ctrl, flg_acc, irq;
  logic [2:0] eng_code;
  logic [BLK_W-1:0] eng_blk;

  int checks = 0, fails = 0;
  logic [6:0] expq[$];

  always #(CLK_PER/2) clk = ~clk;

  flash_cmd_guard #(.NBLK(NBLK), .ACC_W(8)) i_flash_cmd_guard (.*);

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && eng_start) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected start code=%0d blk=%0d, expected none", eng_code, eng_blk);
      end else begin
        logic [6:0] e;
        e = expq.pop_front();
        if ({eng_code, eng_blk} !== e) begin
          fails++;
          $display("FAIL R2: start got %h expected %h", {eng_code, eng_blk}, e);
        end
      end
    end
  end

  task automatic chk(string req, logic [6:0] exp);
    logic [6:0] act;
    act = {op_busy, cmd_locked, flg_acc, flg_ctrl, flg_prog, flg_erase, flg_illegal};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: busy/lock/acc/ctl/prg/ers/ill got %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_irq(string req, logic exp);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq got %b expected %b", req, irq, exp);
    end
  endtask

  task automatic issue(logic [2:0] c, logic [BLK_W-1:0] b, bit exp_start);
    if (exp_start) expq.push_back({c, b});
    cmd_code = c; cmd_blk = b; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic done_pulse();
    eng_done = 1; @(negedge clk); eng_done = 0;
  endtask

  task automatic clear_ok();
    acc_stat = 8'h10; issue(3'd4, 0, 0); acc_stat = 0;
  endtask

  initial begin
    #(CLK_PER*20000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1", 7'b0); chk_irq("R1", 0);
    rst_n = 1; @(negedge clk);
    chk("R1", 7'b0);
    // R2 legal program and erase
    issue(3'd1, 4'd3, 1); chk("R2", 7'b1000000); done_pulse(); chk("R2", 7'b0);
    issue(3'd2, 4'd12, 1); chk("R2", 7'b1000000); done_pulse(); chk("R2", 7'b0);
    // R3 key closed
    irq_en_lock = 1; wen_key = 2'b00;
    issue(3'd1, 4'd2, 0); chk("R3", 7'b0100100); chk_irq("R11", 1);
    clear_ok(); chk("R9", 7'b0); chk_irq("R11", 0);
    issue(3'd2, 4'd2, 0); chk("R3", 7'b0100010);
    acc_stat = 8'h11; issue(3'd4, 0, 0); acc_stat = 0; chk("R9", 7'b0100011);
    clear_ok(); chk("R9", 7'b0);
    wen_key = 2'b01; irq_en_lock = 0;
    // R4 read mode
    mode_ent = 2'b00; issue(3'd2, 4'd1, 0); chk("R4", 7'b0100001);
    mode_ent = 2'b01; clear_ok(); chk("R9", 7'b0);
    // R5 block permission
    blk_wr_ok[7] = 0; issue(3'd1, 4'd7, 0); chk("R5", 7'b0100100);
    clear_ok();
    lock_ovr = 1; issue(3'd1, 4'd7, 1); chk("R5", 7'b1000000); done_pulse();
    lock_ovr = 0; blk_wr_ok = '1;
    // R6 undefined code
    issue(3'd6, 4'd0, 0); chk("R6", 7'b0100001); clear_ok();
    // R7 busy handling, R8 refusal under lock
    issue(3'd1, 4'd1, 1); issue(3'd3, 4'd1, 1); chk("R7", 7'b1000000);
    issue(3'd2, 4'd4, 0); chk("R7", 7'b1100001);
    issue(3'd3, 4'd1, 0); chk("R8", 7'b1100001);
    done_pulse(); chk("R7", 7'b0100001);
    clear_ok(); chk("R9", 7'b0);
    // R10 events, R11 irq
    eng_fault = 1; @(negedge clk); eng_fault = 0; chk("R10", 7'b0101000);
    clear_ok();
    irq_en_acc = 1; acc_viol = 1; @(negedge clk); acc_viol = 0;
    chk("R10", 7'b0110000); chk_irq("R11", 1);
    clear_ok(); chk_irq("R11", 0); irq_en_acc = 0;
    // R12 merged violations
    mode_ent = 2'b00; wen_key = 2'b10; issue(3'd1, 4'd5, 0);
    chk("R12", 7'b0100101);
    mode_ent = 2'b01; wen_key = 2'b01; clear_ok(); chk("R12", 7'b0);
    @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d starts missing, expected 0", expq.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule